// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits behind the write path of a parallel NOR flash model and turns individual bus write cycles into the multi-cycle command protocol such devices expect. It keeps a sequence state that says how far a command has progressed: idle reading, the two unlock steps, the command step, the erase unlock steps, erasing, autoselect, and query mode. From that state and each incoming write it decides whether to advance, fall back to read mode, start a program, or raise an erase request. The state is exported on the `mode` and `cmd_code` pins.

Addresses are compared after a width-dependent shift and a mask to 11 bits, so the same sequencer serves 8-, 16- and 32-bit buses. A program step produces a one-cycle request that is also applied to a small internal byte store. In that store a programmed byte becomes the AND of its old value and the new data, so programming can only clear bits. Sector and chip erase starts are handed to an external erase controller with a valid/ready handshake. The controller signals completion on `erase_done`. A bypass mode lets a host skip the unlock steps and issue repeated programs directly.

Back-pressure: when an erase request is raised, `erase_valid` stays high, with `erase_chip` and `erase_addr` stable, until a cycle in which `erase_ready` is high. During that time `wr_ready` is low and no write is taken. A write is accepted only on a cycle with `wr_valid` and `wr_ready` both high.

Top module: `nor_cmd_seq`

## Requirements
- R1: After synchronous reset, `mode` is 0 (read), `cmd_code` is 0x00, `bypass_on` is 0, `prog_valid` and `erase_valid` are 0, `wr_ready` is 1, and every byte of the store reads 0xFF.
- R2: The byte address is shifted right by 0, 1 or 2 for `bus_width` codes 0, 1 and 2 (code 3 acts as code 2). Only the low 11 bits of the result are compared. The two unlock keys default to word addresses 0x555 (key A) and 0x2AA (key B), masked to 11 bits.
- R3: In mode 0, data 0xAA at key A gives mode 1. In mode 1, data 0x55 at key B gives mode 2. Any other write in these modes gives mode 0.
- R4: In mode 2, the command byte must arrive at key A unless bypass is active. 0xA0 gives mode 3 (`cmd_code` 0xA0), 0x90 gives mode 4 (0x90), 0x80 gives mode 5 (0x80), and 0x20 sets bypass and stays in mode 2. Any other byte, or a wrong address, gives mode 0 and clears bypass.
- R5: Modes 5 and 6 need a second unlock pair (0xAA at key A, then 0x55 at key B), giving mode 7. In mode 7, 0x10 at key A raises a chip erase request and 0x30 at any address raises a sector erase request carrying the full byte address. Both give mode 8, with `cmd_code` 0x10 or 0x30. Any other write gives mode 0.
- R6: An erase request holds until accepted, and `wr_ready` is low while it is pending. In mode 8 every write, 0xF0 included, is ignored. An `erase_done` pulse after acceptance returns to mode 2 if bypass is active, else to mode 0.
- R7: With bypass active, the command step accepts any address. In mode 4 with bypass active, data 0x00 clears bypass and gives mode 0. Bypass is never set in mode 0.
- R8: Data 0xF0 gives mode 0 and clears bypass from any mode except 3 and 8. In mode 10 it gives mode 4 instead. In mode 3, 0xF0 is program data.
- R9: Data 0x98 at word address 0x55 gives query mode: mode 9 from modes 0 and 5, mode 10 from mode 4. `cmd_code` is 0x98 in both. Any write other than 0xF0 in mode 9 or 10 gives mode 0.
- R10: A write in mode 3 produces `prog_valid` for exactly one cycle, on the cycle after the write. It carries the address aligned down to the bus width, the data, and the size code. In the store, the byte lanes (little-endian, lane i from bits 8i+7..8i) become the old value AND the new data. The sequencer then goes to mode 2 if bypass is active, else to mode 0.
- R11: With `write_protect` high during the program request, the request is still issued and sequencing is unchanged, but the store keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_width | input | 2 | Bus width code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| write_protect | input | 1 | Blocks store updates |
| wr_valid | input | 1 | Bus write present |
| wr_ready | output | 1 | Write accepted this cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data; the low byte is the command byte |
| erase_done | input | 1 | Erase controller finished |
| mode | output | 4 | Sequence state code (see requirements) |
| cmd_code | output | 8 | Active command byte |
| bypass_on | output | 1 | Unlock bypass active |
| prog_valid | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Aligned program address |
| prog_data | output | 32 | Program data |
| prog_size | output | 2 | Program size code (shift amount) |
| erase_valid | output | 1 | Erase request pending |
| erase_ready | input | 1 | Erase controller takes the request |
| erase_chip | output | 1 | 1 = chip erase, 0 = sector erase |
| erase_addr | output | ADDR_W | Byte address inside the sector to erase |
| peek_addr | input | log2(MEM_BYTES) | Store byte index to observe |
| peek_data | output | 8 | Store byte at `peek_addr` |

## Verification
Directed sequences walk each path through the state machine once:
- the complete unlock-command-program path on each bus width;
- unlock addresses with junk in their upper bits and in their lane bits;
- a corrupted unlock step;
- bypass with its exit;
- both query entries and their differing 0xF0 returns;
- chip and sector erase with a stalled acceptance.

The shifted-address cases tell a correct width-dependent comparison from one that ignores the width or compares more than 11 bits. Programming the same byte twice tells AND-merging from overwriting. The write-protected program tells a request that is issued but not applied from one that is dropped. A long stream of constrained-random writes is then biased toward command bytes and key addresses. It mixes widths and reaches rare orderings such as a query from the erase unlock step and a reset in the middle of a sequence. It is compared write by write against a reference model, and the whole store is compared at the end.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  localparam int CMP_W = 11;

  typedef enum logic [3:0] {
    M_READ     = 4'd0,
    M_UNLK1    = 4'd1,
    M_CMD      = 4'd2,
    M_PROG     = 4'd3,
    M_AUTO     = 4'd4,
    M_EUNLK0   = 4'd5,
    M_EUNLK1   = 4'd6,
    M_ESEL     = 4'd7,
    M_ERASE    = 4'd8,
    M_QUERY    = 4'd9,
    M_QUERY_AS = 4'd10
  } seq_mode_e;

  localparam logic [7:0] OP_KEY_A   = 8'hAA;
  localparam logic [7:0] OP_KEY_B   = 8'h55;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_AUTO    = 8'h90;
  localparam logic [7:0] OP_PROG    = 8'hA0;
  localparam logic [7:0] OP_BYPASS  = 8'h20;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_RESET   = 8'hF0;
  localparam logic [7:0] OP_CHIP    = 8'h10;
  localparam logic [7:0] OP_SECTOR  = 8'h30;
  localparam logic [7:0] OP_BYP_OUT = 8'h00;

  localparam logic [CMP_W-1:0] QUERY_WADDR = 11'h055;

endpackage

// File: rtl/nor_addr_norm.sv
module nor_addr_norm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [1:0]        bus_width,
  output logic [1:0]        lane_shift,
  output logic [CMP_W-1:0]  word_addr
);

  logic [ADDR_W-1:0] shifted;

  always_comb begin
    case (bus_width)
      2'd0:    lane_shift = 2'd0;
      2'd1:    lane_shift = 2'd1;
      default: lane_shift = 2'd2;
    endcase
    shifted   = byte_addr >> lane_shift;
    word_addr = shifted[CMP_W-1:0];
  end

endmodule

// File: rtl/nor_seq_core.sv
module nor_seq_core
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int UNLOCK_A = 32'h555,
  parameter int UNLOCK_B = 32'h2AA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [CMP_W-1:0]  word_addr,
  input  logic [1:0]        lane_shift,
  input  logic              erase_done,
  input  logic              erase_ready,
  output seq_mode_e         mode,
  output logic [7:0]        cmd_code,
  output logic              bypass_on,
  output logic              prog_valid,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [31:0]       prog_data,
  output logic [1:0]        prog_size,
  output logic              erase_valid,
  output logic              erase_chip,
  output logic [ADDR_W-1:0] erase_addr
);

  localparam logic [CMP_W-1:0] KEY_A = CMP_W'(UNLOCK_A & 32'h7FF);
  localparam logic [CMP_W-1:0] KEY_B = CMP_W'(UNLOCK_B & 32'h7FF);

  seq_mode_e         mode_q, mode_n;
  logic              byp_q, byp_n;
  logic              chip_q, chip_n;
  logic              prog_fire, erase_fire;
  logic [7:0]        op;
  logic              at_a, at_b, query_hit;
  logic [ADDR_W-1:0] aligned;

  assign op        = wr_data[7:0];
  assign at_a      = (word_addr == KEY_A);
  assign at_b      = (word_addr == KEY_B);
  assign query_hit = (word_addr == QUERY_WADDR) && (op == OP_QUERY);

  always_comb begin
    case (lane_shift)
      2'd1:    aligned = {wr_addr[ADDR_W-1:1], 1'b0};
      2'd2:    aligned = {wr_addr[ADDR_W-1:2], 2'b00};
      default: aligned = wr_addr;
    endcase
  end

  always_comb begin
    mode_n     = mode_q;
    byp_n      = byp_q;
    chip_n     = chip_q;
    prog_fire  = 1'b0;
    erase_fire = 1'b0;
    if (mode_q == M_ERASE) begin
      if (erase_done && !erase_valid)
        mode_n = byp_q ? M_CMD : M_READ;
    end else if (wr_fire) begin
      if (op == OP_RESET && mode_q != M_PROG) begin
        if (mode_q == M_QUERY_AS) begin
          mode_n = M_AUTO;
        end else begin
          mode_n = M_READ;
          byp_n  = 1'b0;
        end
      end else begin
        mode_n = M_READ;
        byp_n  = 1'b0;
        case (mode_q)
          M_READ, M_EUNLK0: begin
            if (query_hit) begin
              mode_n = M_QUERY;
              byp_n  = byp_q;
            end else if (op == OP_KEY_A && at_a) begin
              mode_n = (mode_q == M_READ) ? M_UNLK1 : M_EUNLK1;
              byp_n  = byp_q;
            end
          end
          M_UNLK1, M_EUNLK1: begin
            if (op == OP_KEY_B && at_b) begin
              mode_n = (mode_q == M_UNLK1) ? M_CMD : M_ESEL;
              byp_n  = byp_q;
            end
          end
          M_CMD: begin
            if (byp_q || at_a) begin
              byp_n = byp_q;
              case (op)
                OP_BYPASS: begin mode_n = M_CMD; byp_n = 1'b1; end
                OP_ERASE:  mode_n = M_EUNLK0;
                OP_AUTO:   mode_n = M_AUTO;
                OP_PROG:   mode_n = M_PROG;
                default:   begin mode_n = M_READ; byp_n = 1'b0; end
              endcase
            end
          end
          M_PROG: begin
            prog_fire = 1'b1;
            byp_n     = byp_q;
            mode_n    = byp_q ? M_CMD : M_READ;
          end
          M_AUTO: begin
            if (!(byp_q && op == OP_BYP_OUT) && query_hit) begin
              mode_n = M_QUERY_AS;
              byp_n  = byp_q;
            end
          end
          M_ESEL: begin
            if (op == OP_CHIP && at_a) begin
              mode_n = M_ERASE; byp_n = byp_q; chip_n = 1'b1; erase_fire = 1'b1;
            end else if (op == OP_SECTOR) begin
              mode_n = M_ERASE; byp_n = byp_q; chip_n = 1'b0; erase_fire = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= M_READ;
      byp_q       <= 1'b0;
      chip_q      <= 1'b0;
      prog_valid  <= 1'b0;
      prog_addr   <= '0;
      prog_data   <= '0;
      prog_size   <= '0;
      erase_valid <= 1'b0;
      erase_addr  <= '0;
    end else begin
      mode_q     <= mode_n;
      byp_q      <= byp_n;
      chip_q     <= chip_n;
      prog_valid <= prog_fire;
      if (prog_fire) begin
        prog_addr <= aligned;
        prog_data <= wr_data;
        prog_size <= lane_shift;
      end
      if (erase_fire) begin
        erase_valid <= 1'b1;
        erase_addr  <= wr_addr;
      end else if (erase_ready) begin
        erase_valid <= 1'b0;
      end
    end
  end

  always_comb begin
    case (mode_q)
      M_PROG:              cmd_code = OP_PROG;
      M_AUTO:              cmd_code = OP_AUTO;
      M_EUNLK0, M_EUNLK1,
      M_ESEL:              cmd_code = OP_ERASE;
      M_ERASE:             cmd_code = chip_q ? OP_CHIP : OP_SECTOR;
      M_QUERY, M_QUERY_AS: cmd_code = OP_QUERY;
      default:             cmd_code = 8'h00;
    endcase
  end

  assign mode       = mode_q;
  assign bypass_on  = byp_q;
  assign erase_chip = chip_q;

endmodule

// File: rtl/nor_byte_store.sv
module nor_byte_store #(
  parameter int ADDR_W    = 24,
  parameter int MEM_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        wr_size,
  input  logic [$clog2(MEM_BYTES)-1:0] peek_addr,
  output logic [7:0]        peek_data
);

  localparam int IDX_W = $clog2(MEM_BYTES);
  localparam int LANES = 4;

  logic [7:0]       mem [MEM_BYTES];
  logic [IDX_W-1:0] lane_idx [LANES];
  logic [LANES-1:0] lane_on;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_idx[g] = wr_addr[IDX_W-1:0] + IDX_W'(g);
    assign lane_on[g]  = wr_en && (32'(g) < (32'd1 << wr_size));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < LANES; i++)
        if (lane_on[i]) mem[lane_idx[i]] <= mem[lane_idx[i]] & wr_data[8*i +: 8];
    end
  end

  assign peek_data = mem[peek_addr];

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MEM_BYTES = 64,
  parameter int UNLOCK_A  = 32'h555,
  parameter int UNLOCK_B  = 32'h2AA,
  localparam int PEEK_W   = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_width,
  input  logic              write_protect,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              erase_done,
  output logic [3:0]        mode,
  output logic [7:0]        cmd_code,
  output logic              bypass_on,
  output logic              prog_valid,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [31:0]       prog_data,
  output logic [1:0]        prog_size,
  output logic              erase_valid,
  input  logic              erase_ready,
  output logic              erase_chip,
  output logic [ADDR_W-1:0] erase_addr,
  input  logic [PEEK_W-1:0] peek_addr,
  output logic [7:0]        peek_data
);

  logic [1:0]       lane_shift;
  logic [CMP_W-1:0] word_addr;
  logic             wr_fire;
  seq_mode_e        mode_e;

  assign wr_ready = !erase_valid;
  assign wr_fire  = wr_valid && wr_ready;
  assign mode     = mode_e;

  nor_addr_norm #(.ADDR_W(ADDR_W)) u_norm (
    .byte_addr (wr_addr),
    .bus_width (bus_width),
    .lane_shift(lane_shift),
    .word_addr (word_addr)
  );

  nor_seq_core #(
    .ADDR_W  (ADDR_W),
    .UNLOCK_A(UNLOCK_A),
    .UNLOCK_B(UNLOCK_B)
  ) u_core (
    .clk        (clk),
    .rst        (rst),
    .wr_fire    (wr_fire),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .word_addr  (word_addr),
    .lane_shift (lane_shift),
    .erase_done (erase_done),
    .erase_ready(erase_ready),
    .mode       (mode_e),
    .cmd_code   (cmd_code),
    .bypass_on  (bypass_on),
    .prog_valid (prog_valid),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .prog_size  (prog_size),
    .erase_valid(erase_valid),
    .erase_chip (erase_chip),
    .erase_addr (erase_addr)
  );

  nor_byte_store #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (prog_valid && !write_protect),
    .wr_addr  (prog_addr),
    .wr_data  (prog_data),
    .wr_size  (prog_size),
    .peek_addr(peek_addr),
    .peek_data(peek_data)
  );

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [31:0]       wr_data,
  input logic [3:0]        mode,
  input logic              bypass_on,
  input logic              prog_valid,
  input logic              erase_valid,
  input logic              erase_ready,
  input logic              erase_chip,
  input logic [ADDR_W-1:0] erase_addr,
  input logic              erase_done
);

  AST_ERQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    erase_valid && !erase_ready |=> erase_valid && $stable(erase_addr) && $stable(erase_chip)); // R6
  AST_ERQ_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(erase_valid) |-> mode == 4'd8); // R5
  AST_ERASE_STICKY: assert property (@(posedge clk) disable iff (rst)
    mode == 4'd8 && !erase_done |=> mode == 4'd8); // R6
  AST_PROG_PULSE: assert property (@(posedge clk) disable iff (rst)
    prog_valid |=> !prog_valid); // R10
  AST_PROG_SOURCE: assert property (@(posedge clk) disable iff (rst)
    prog_valid |-> $past(mode) == 4'd3); // R10
  AST_READ_NO_BYPASS: assert property (@(posedge clk) disable iff (rst)
    mode == 4'd0 |-> !bypass_on); // R7
  AST_QUERY_BACK: assert property (@(posedge clk) disable iff (rst)
    wr_valid && wr_ready && mode == 4'd10 && wr_data[7:0] == 8'hF0 |=> mode == 4'd4); // R8

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_data    (wr_data),
  .mode       (mode),
  .bypass_on  (bypass_on),
  .prog_valid (prog_valid),
  .erase_valid(erase_valid),
  .erase_ready(erase_ready),
  .erase_chip (erase_chip),
  .erase_addr (erase_addr),
  .erase_done (erase_done)
);

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int MB = 64;
  localparam logic [10:0] KA = 11'h555;
  localparam logic [10:0] KB = 11'h2AA;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    bus_width = 2'd0;
  logic          write_protect = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          erase_done = 1'b0;
  logic [3:0]    mode;
  logic [7:0]    cmd_code;
  logic          bypass_on;
  logic          prog_valid;
  logic [AW-1:0] prog_addr;
  logic [31:0]   prog_data;
  logic [1:0]    prog_size;
  logic          erase_valid;
  logic          erase_ready = 1'b1;
  logic          erase_chip;
  logic [AW-1:0] erase_addr;
  logic [5:0]    peek_addr = '0;
  logic [7:0]    peek_data;

  int n_chk  = 0;
  int n_fail = 0;

  int         m_mode = 0;
  bit         m_byp  = 1'b0;
  bit         m_chip = 1'b0;
  logic [7:0] m_mem [MB];

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_seq uut (
    .clk(clk), .rst(rst), .bus_width(bus_width), .write_protect(write_protect),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .erase_done(erase_done), .mode(mode), .cmd_code(cmd_code), .bypass_on(bypass_on),
    .prog_valid(prog_valid), .prog_addr(prog_addr), .prog_data(prog_data),
    .prog_size(prog_size), .erase_valid(erase_valid), .erase_ready(erase_ready),
    .erase_chip(erase_chip), .erase_addr(erase_addr), .peek_addr(peek_addr),
    .peek_data(peek_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int shift_of(input logic [1:0] bw);
    return (bw == 2'd0) ? 0 : (bw == 2'd1) ? 1 : 2;
  endfunction

  function automatic logic [7:0] exp_cmd();
    case (m_mode)
      3: return 8'hA0;
      4: return 8'h90;
      5, 6, 7: return 8'h80;
      8: return m_chip ? 8'h10 : 8'h30;
      9, 10: return 8'h98;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [AW-1:0] wa(input logic [10:0] w);
    return AW'(w) << shift_of(bus_width);
  endfunction

  task automatic go_idle();
    m_mode = 0;
    m_byp  = 1'b0;
  endtask

  // reference model written from the requirements
  task automatic m_step(input logic [AW-1:0] a, input logic [31:0] d, input bit wp,
                        output bit pf, output logic [AW-1:0] pa, output bit ef);
    int sh = shift_of(bus_width);
    logic [AW-1:0] sa = a >> sh;
    logic [10:0] w = sa[10:0];
    logic [7:0] b = d[7:0];
    bit qh = (w == 11'h055) && (b == 8'h98);
    pf = 1'b0; ef = 1'b0; pa = '0;
    if (m_mode == 8) return;
    if (b == 8'hF0 && m_mode != 3) begin
      if (m_mode == 10) m_mode = 4; else go_idle();
      return;
    end
    case (m_mode)
      0, 5: if (qh) m_mode = 9;
            else if (b == 8'hAA && w == KA) m_mode = (m_mode == 0) ? 1 : 6;
            else go_idle();
      1, 6: if (b == 8'h55 && w == KB) m_mode = (m_mode == 1) ? 2 : 7;
            else go_idle();
      2: if (!m_byp && w != KA) go_idle();
         else if (b == 8'h20) m_byp = 1'b1;
         else if (b == 8'h80) m_mode = 5;
         else if (b == 8'h90) m_mode = 4;
         else if (b == 8'hA0) m_mode = 3;
         else go_idle();
      3: begin
        pf = 1'b1;
        pa = (a >> sh) << sh;
        for (int i = 0; i < (1 << sh); i++)
          if (!wp) m_mem[(32'(pa) + i) % MB] = m_mem[(32'(pa) + i) % MB] & d[8*i +: 8];
        m_mode = m_byp ? 2 : 0;
      end
      4: if (m_byp && b == 8'h00) go_idle();
         else if (qh) m_mode = 10;
         else go_idle();
      7: if (b == 8'h10 && w == KA) begin m_mode = 8; m_chip = 1'b1; ef = 1'b1; end
         else if (b == 8'h30) begin m_mode = 8; m_chip = 1'b0; ef = 1'b1; end
         else go_idle();
      default: go_idle();
    endcase
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bit pf, ef;
    logic [AW-1:0] pa;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    m_step(a, d, write_protect, pf, pa, ef);
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R3 mode", 32'(mode), 32'(m_mode));
    chk("R7 bypass", 32'(bypass_on), 32'(m_byp));
    chk("R4 cmd_code", 32'(cmd_code), 32'(exp_cmd()));
    chk("R10 prog_valid", 32'(prog_valid), 32'(pf));
    if (pf) begin
      chk("R10 prog_addr", 32'(prog_addr), 32'(pa));
      chk("R10 prog_data", prog_data, d);
      chk("R10 prog_size", 32'(prog_size), 32'(shift_of(bus_width)));
    end
    if (ef) begin
      chk("R5 erase_valid", 32'(erase_valid), 32'd1);
      chk("R5 erase_chip", 32'(erase_chip), 32'(m_chip));
      chk("R5 erase_addr", 32'(erase_addr), 32'(a));
    end
  endtask

  task automatic unlock();
    wr(wa(KA), 32'hAA);
    wr(wa(KB), 32'h55);
  endtask

  task automatic finish_erase();
    @(negedge clk);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    m_mode = m_byp ? 2 : 0;
    chk("R6 erase_done return", 32'(mode), 32'(m_mode));
  endtask

  task automatic peek_chk(input int idx, input logic [7:0] exp, input string req);
    @(negedge clk);
    peek_addr = 6'(idx);
    #1;
    chk(req, 32'(peek_data), 32'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < MB; i++) m_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", 32'(mode), 32'd0);
    chk("R1 cmd_code", 32'(cmd_code), 32'd0);
    chk("R1 bypass", 32'(bypass_on), 32'd0);
    chk("R1 prog_valid", 32'(prog_valid), 32'd0);
    chk("R1 erase_valid", 32'(erase_valid), 32'd0);
    chk("R1 wr_ready", 32'(wr_ready), 32'd1);
    peek_chk(17, 8'hFF, "R1 store");

    // R3 R4 R10 byte program, then AND merge (0xF0 as data, R8)
    unlock();
    chk("R3 after unlock", 32'(mode), 32'd2);
    wr(wa(KA), 32'hA0);
    chk("R4 program entry", 32'(mode), 32'd3);
    wr(24'h000010, 32'h0000003C);
    peek_chk(16, 8'h3C, "R10 stored");
    unlock(); wr(wa(KA), 32'hA0);
    wr(24'h000010, 32'h000000F0);
    chk("R8 F0 in program", 32'(mode), 32'd0);
    peek_chk(16, 8'h30, "R10 AND merge");

    // R2 16-bit bus with junk in upper and lane bits
    bus_width = 2'd1;
    wr(24'hF00AAB, 32'hAA);
    chk("R2 masked key A", 32'(mode), 32'd1);
    wr(24'h300554, 32'h55);
    wr(24'h000AAA, 32'hA0);
    chk("R2 16-bit program entry", 32'(mode), 32'd3);
    wr(24'h000021, 32'h00001234);
    chk("R10 aligned", 32'(prog_addr), 32'h20);
    peek_chk(32, 8'h34, "R10 lane 0");
    peek_chk(33, 8'h12, "R10 lane 1");
    wr(24'h000555, 32'hAA);
    chk("R2 unshifted key rejected", 32'(mode), 32'd0);

    // R3 corrupted second step, R8 reset mid-sequence
    bus_width = 2'd0;
    wr(wa(KA), 32'hAA); wr(wa(KB), 32'h54);
    chk("R3 bad key B", 32'(mode), 32'd0);
    wr(wa(KA), 32'hAA); wr(wa(KB), 32'hF0);
    chk("R8 reset in unlock", 32'(mode), 32'd0);

    // R7 bypass
    unlock(); wr(wa(KA), 32'h20);
    chk("R7 bypass set", 32'(bypass_on), 32'd1);
    wr(24'h000123, 32'hA0);
    chk("R7 any address", 32'(mode), 32'd3);
    wr(24'h000008, 32'h0000000F);
    chk("R7 back to command", 32'(mode), 32'd2);
    wr(24'h000077, 32'h90);
    wr(24'h000001, 32'h00);
    chk("R7 bypass exit", 32'(bypass_on), 32'd0);
    chk("R7 exit mode", 32'(mode), 32'd0);

    // R9 R8 query paths
    unlock(); wr(wa(KA), 32'h90);
    wr(24'h000055, 32'h98);
    chk("R9 query from autoselect", 32'(mode), 32'd10);
    wr(24'h000000, 32'hF0);
    chk("R8 return to autoselect", 32'(mode), 32'd4);
    wr(24'h000055, 32'h98);
    wr(24'h000000, 32'h12);
    chk("R9 write leaves query", 32'(mode), 32'd0);
    wr(24'h000055, 32'h98);
    chk("R9 query from read", 32'(mode), 32'd9);
    wr(24'h000000, 32'hF0);
    chk("R8 query reset", 32'(mode), 32'd0);

    // R5 R6 chip erase with stalled acceptance
    unlock(); wr(wa(KA), 32'h80); unlock();
    chk("R5 erase select", 32'(mode), 32'd7);
    erase_ready = 1'b0;
    wr(wa(KA), 32'h10);
    chk("R5 chip cmd", 32'(cmd_code), 32'h10);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 request held", 32'(erase_valid), 32'd1);
      chk("R6 write stalled", 32'(wr_ready), 32'd0);
    end
    erase_ready = 1'b1;
    @(negedge clk);
    chk("R6 request taken", 32'(erase_valid), 32'd0);
    wr(wa(KA), 32'hF0);
    chk("R6 F0 ignored", 32'(mode), 32'd8);
    finish_erase();

    // R5 sector erase and bad select
    unlock(); wr(wa(KA), 32'h80); unlock();
    wr(24'h001234, 32'h30);
    chk("R5 sector addr", 32'(erase_addr), 32'h1234);
    finish_erase();
    unlock(); wr(wa(KA), 32'h80); unlock();
    wr(24'h000100, 32'h10);
    chk("R5 chip at wrong address", 32'(mode), 32'd0);

    // R11 write protect
    @(negedge clk); write_protect = 1'b1;
    unlock(); wr(wa(KA), 32'hA0);
    wr(24'h000005, 32'h00);
    chk("R11 request issued", 32'(prog_addr), 32'h5);
    @(negedge clk); write_protect = 1'b0;
    peek_chk(5, 8'hFF, "R11 store kept");

    // random phase
    for (int it = 0; it < 2500; it++) begin
      logic [AW-1:0] a;
      logic [31:0]   d;
      logic [10:0]   w;
      int sh;
      @(negedge clk);
      if (m_mode == 8) begin finish_erase(); continue; end
      if ($urandom_range(0, 7) == 0) bus_width = 2'($urandom_range(0, 3));
      write_protect = ($urandom_range(0, 9) == 0);
      sh = shift_of(bus_width);
      case ($urandom_range(0, 3))
        0: w = KA;
        1: w = KB;
        2: w = 11'h055;
        default: w = 11'($urandom);
      endcase
      a = (AW'(w) << sh) | AW'($urandom & ((1 << sh) - 1));
      if ($urandom_range(0, 1) == 1) a = a | (AW'($urandom) << (11 + sh));
      d = $urandom;
      if (m_mode != 3 || $urandom_range(0, 3) == 0) begin
        case ($urandom_range(0, 11))
          0: d[7:0] = 8'hAA;  1: d[7:0] = 8'h55;  2: d[7:0] = 8'h80;
          3: d[7:0] = 8'h90;  4: d[7:0] = 8'hA0;  5: d[7:0] = 8'h20;
          6: d[7:0] = 8'h98;  7: d[7:0] = 8'hF0;  8: d[7:0] = 8'h10;
          9: d[7:0] = 8'h30; 10: d[7:0] = 8'h00;
          default: ;
        endcase
      end
      wr(a, d);
    end
    @(negedge clk);
    write_protect = 1'b0;
    for (int i = 0; i < MB; i++) peek_chk(i, m_mem[i], "R10 R11 final store");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule